// File: doc/BRIEF.md
# Audio Master/Bit Clock Ratio Generator

This block derives the timing strobes of a serial audio port from its master clock. Two 3-bit codes set the number of master clocks per audio sample and the number of bit clocks per frame. From these the block produces a one-cycle bit-clock enable (`bit_tick`) and a frame clock level (`frame_clk`) that is low for the first half of each frame and high for the second. The bit-clock divide is the master ratio divided by the bits-per-frame value.

The port either drives its clocks, when `drive_clks` is high, or receives them from a partner device. When receiving, the generated strobes stay quiet. The externally supplied bit and frame clocks are then passed through a register with their own polarity controls. The whole generator is gated by a port clock enable. Software programs the ratio codes and waits about 10 µs before raising that enable. The extended codes (32 clocks per sample, 16 bits per frame) are honoured only when `wide_codes` is set.

Top module: `audio_clk_ratio_gen`

## Requirements
- R1: While reset is asserted, `bit_tick` is 0, `frame_clk` equals `frame_inv_drv`, and both received clock outputs are 0.
- R2: `mclk_fs_code` values 0, 1, 2 and 3 give frames of 512, 256, 128 and 64 master cycles. `frame_clk` (before inversion) is low for the first half of each frame and high for the second.
- R3: `bits_frame_code` values 0, 1, 2, 3 and 4 give 32, 64, 128, 256 and 512 bits per frame. `bit_tick` pulses once every (frame length / bits per frame) master cycles. With no bit inversion, the pulse falls in the last master cycle of each bit period.
- R4: `mclk_fs_code` 4 gives 32 master cycles per frame, and `bits_frame_code` 7 gives 16 bits per frame. Both apply only while `wide_codes` is 1. With `wide_codes` 0 they decode as 512 and 32.
- R5: Any other code (`mclk_fs_code` 5–7, `bits_frame_code` 5–6) decodes as 512 master cycles per frame or 32 bits per frame.
- R6: When bits per frame exceed master cycles per frame, `cfg_bad` is 1 and, from the next cycle, `bit_tick` stays 0 and `frame_clk` stays at its idle level (`frame_inv_drv`).
- R7: With `drive_clks` 0, from the next cycle, `bit_tick` is 0 and `frame_clk` is at its idle level.
- R8: With `port_en` 0, from the next cycle, the strobes are idle. After `port_en` rises, the counter starts from zero: the first cycle of the first frame is low-phase.
- R9: `frame_inv_drv` = 1 inverts `frame_clk` in every cycle, including when idle.
- R10: `bit_inv_drv` = 1 moves the `bit_tick` pulse half a bit period earlier, to master cycle 2^(d-1)-1 of each bit period (period 2^d, d ≥ 1). When d = 0 it pulses every cycle.
- R11: `rcv_bit_clk` and `rcv_frame_clk` equal the previous cycle's `ext_bit_clk ^ bit_inv_rcv` and `ext_frame_clk ^ frame_inv_rcv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port clock enable, gates the generator |
| drive_clks | input | 1 | 1: port drives its clocks, 0: port receives them |
| wide_codes | input | 1 | Enables the extended ratio codes |
| mclk_fs_code | input | 3 | Master clocks per sample code |
| bits_frame_code | input | 3 | Bit clocks per frame code |
| frame_inv_drv | input | 1 | Inverts the generated frame clock |
| bit_inv_drv | input | 1 | Shifts the generated bit strobe by half a bit |
| frame_inv_rcv | input | 1 | Inverts the received frame clock |
| bit_inv_rcv | input | 1 | Inverts the received bit clock |
| ext_bit_clk | input | 1 | Bit clock from the partner device |
| ext_frame_clk | input | 1 | Frame clock from the partner device |
| bit_tick | output | 1 | One-cycle bit-clock enable |
| frame_clk | output | 1 | Generated frame clock level |
| rcv_bit_clk | output | 1 | Registered, polarity-adjusted received bit clock |
| rcv_frame_clk | output | 1 | Registered, polarity-adjusted received frame clock |
| cfg_bad | output | 1 | Ratio pair is illegal |

## Verification
A bit strobe and a frame-clock edge fall on the same frame boundary. The last bit pulse of each half frame lands in the cycle just before `frame_clk` changes level. With a divide of one, both even share every boundary cycle. The bench runs ratio pairs with bit divides of 1, 2, 4 and 16. A scoreboard compares both outputs on every master cycle against values computed from the frame position, so any skew between the two shows up as a mismatch. Disabling the port right after the last expected strobe checks that gating and counting do not interfere.

// File: rtl/aclk_pkg.sv
// Shared constants and ratio decode functions for the audio clock ratio generator.
// Assumes codes are 3 bits wide; ratios are returned as base-2 logarithms.
package aclk_pkg;
    localparam int CODE_W  = 3;
    localparam int LOG_W   = 4;
    localparam int MAX_LOG = 9;

    // master clocks per sample, as log2
    function automatic logic [LOG_W-1:0] fs_ratio_log(input logic [CODE_W-1:0] code,
                                                      input logic wide);
        case (code)
            3'd0:    fs_ratio_log = 4'd9;
            3'd1:    fs_ratio_log = 4'd8;
            3'd2:    fs_ratio_log = 4'd7;
            3'd3:    fs_ratio_log = 4'd6;
            3'd4:    fs_ratio_log = wide ? 4'd5 : 4'd9;
            default: fs_ratio_log = 4'd9;
        endcase
    endfunction

    // bit clocks per frame, as log2
    function automatic logic [LOG_W-1:0] bpf_log(input logic [CODE_W-1:0] code,
                                                 input logic wide);
        case (code)
            3'd0:    bpf_log = 4'd5;
            3'd1:    bpf_log = 4'd6;
            3'd2:    bpf_log = 4'd7;
            3'd3:    bpf_log = 4'd8;
            3'd4:    bpf_log = 4'd9;
            3'd7:    bpf_log = wide ? 4'd4 : 4'd5;
            default: bpf_log = 4'd5;
        endcase
    endfunction
endpackage

// File: rtl/aclk_ratio_decode.sv
// Turns the two ratio codes into frame length and bit divide (both log2) and
// flags pairs whose bit count exceeds the master cycles per frame.
// Assumes codes are static while the port runs.
module aclk_ratio_decode
    import aclk_pkg::*;
(
    input  logic [CODE_W-1:0] fs_code,
    input  logic [CODE_W-1:0] bf_code,
    input  logic              wide,
    output logic [LOG_W-1:0]  frame_log,
    output logic [LOG_W-1:0]  div_log,
    output logic              bad
);
    logic [LOG_W-1:0] bits_log;

    // decode both tables and derive the divide
    always_comb begin
        frame_log = fs_ratio_log(fs_code, wide);
        bits_log  = bpf_log(bf_code, wide);
        bad       = (frame_log < bits_log);
        div_log   = bad ? '0 : (frame_log - bits_log);
    end
endmodule

// File: rtl/aclk_frame_counter.sv
// Master-cycle position counter within a frame. Idles at zero while not running,
// so the first cycle after a start is position zero.
module aclk_frame_counter #(
    parameter int CNT_W = 9,
    parameter int LOG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic [LOG_W-1:0] frame_log,
    output logic             run_q,
    output logic [CNT_W-1:0] pos
);
    logic [CNT_W-1:0] wrap_mask;

    // mask for frame length 2**frame_log (all ones when it equals 2**CNT_W)
    always_comb wrap_mask = (CNT_W'(1) << frame_log) - CNT_W'(1);

    // register the run request and advance the frame position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            pos   <= '0;
        end else begin
            run_q <= run_req;
            if (run_q) pos <= (pos + CNT_W'(1)) & wrap_mask;
            else       pos <= '0;
        end
    end
endmodule

// File: rtl/aclk_strobe_out.sv
// Forms the bit strobe and frame level from the frame position, applies the
// drive-side polarity controls and registers the received clocks.
module aclk_strobe_out #(
    parameter int CNT_W  = 9,
    parameter int LOG_W  = 4,
    parameter int N_RCV  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_q,
    input  logic [CNT_W-1:0] pos,
    input  logic [LOG_W-1:0] frame_log,
    input  logic [LOG_W-1:0] div_log,
    input  logic             bit_inv,
    input  logic             frame_inv,
    input  logic [N_RCV-1:0] rcv_in,
    input  logic [N_RCV-1:0] rcv_inv,
    output logic             tick,
    output logic             frame_lvl,
    output logic [N_RCV-1:0] rcv_out
);
    logic [CNT_W-1:0] bit_mask;
    logic [CNT_W-1:0] tick_at;
    logic [CNT_W-1:0] half_sel;

    // choose the strobe cycle within each bit period and the frame phase
    always_comb begin
        bit_mask  = (CNT_W'(1) << div_log) - CNT_W'(1);
        tick_at   = bit_inv ? (bit_mask >> 1) : bit_mask;
        half_sel  = pos >> (frame_log - LOG_W'(1));
        tick      = run_q && ((pos & bit_mask) == tick_at);
        frame_lvl = (run_q & half_sel[0]) ^ frame_inv;
    end

    for (genvar g = 0; g < N_RCV; g++) begin : g_rcv
        // register one received clock with its polarity control
        always_ff @(posedge clk) begin
            if (!rst_n) rcv_out[g] <= 1'b0;
            else        rcv_out[g] <= rcv_in[g] ^ rcv_inv[g];
        end
    end
endmodule

// File: rtl/audio_clk_ratio_gen.sv
// Audio master/bit clock ratio generator: bit strobe and frame clock derived
// from the master clock by coded ratios, with drive/receive selection,
// polarity controls and port enable gating.
module audio_clk_ratio_gen
    import aclk_pkg::*;
#(
    parameter int CNT_W = MAX_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              drive_clks,
    input  logic              wide_codes,
    input  logic [CODE_W-1:0] mclk_fs_code,
    input  logic [CODE_W-1:0] bits_frame_code,
    input  logic              frame_inv_drv,
    input  logic              bit_inv_drv,
    input  logic              frame_inv_rcv,
    input  logic              bit_inv_rcv,
    input  logic              ext_bit_clk,
    input  logic              ext_frame_clk,
    output logic              bit_tick,
    output logic              frame_clk,
    output logic              rcv_bit_clk,
    output logic              rcv_frame_clk,
    output logic              cfg_bad
);
    logic [LOG_W-1:0] frame_log;
    logic [LOG_W-1:0] div_log;
    logic             run_req;
    logic             run_q;
    logic [CNT_W-1:0] pos;
    logic [1:0]       rcv_q;

    aclk_ratio_decode u_dec (
        .fs_code   (mclk_fs_code),
        .bf_code   (bits_frame_code),
        .wide      (wide_codes),
        .frame_log (frame_log),
        .div_log   (div_log),
        .bad       (cfg_bad)
    );

    // run only when enabled, driving, and legally configured
    always_comb run_req = port_en && drive_clks && !cfg_bad;

    aclk_frame_counter #(.CNT_W(CNT_W), .LOG_W(LOG_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_req   (run_req),
        .frame_log (frame_log),
        .run_q     (run_q),
        .pos       (pos)
    );

    aclk_strobe_out #(.CNT_W(CNT_W), .LOG_W(LOG_W), .N_RCV(2)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_q     (run_q),
        .pos       (pos),
        .frame_log (frame_log),
        .div_log   (div_log),
        .bit_inv   (bit_inv_drv),
        .frame_inv (frame_inv_drv),
        .rcv_in    ({ext_frame_clk, ext_bit_clk}),
        .rcv_inv   ({frame_inv_rcv, bit_inv_rcv}),
        .tick      (bit_tick),
        .frame_lvl (frame_clk),
        .rcv_out   (rcv_q)
    );

    assign rcv_bit_clk   = rcv_q[0];
    assign rcv_frame_clk = rcv_q[1];
endmodule

// File: rtl/aclk_ratio_checker.sv
// Property checker for audio_clk_ratio_gen, bound to every instance.
module aclk_ratio_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       port_en,
    input logic       drive_clks,
    input logic       frame_inv_drv,
    input logic       frame_inv_rcv,
    input logic       bit_inv_rcv,
    input logic       ext_bit_clk,
    input logic       ext_frame_clk,
    input logic       bit_tick,
    input logic       frame_clk,
    input logic       rcv_bit_clk,
    input logic       rcv_frame_clk,
    input logic       cfg_bad
);
    a_r7_receive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_clks |=> (!bit_tick && frame_clk == frame_inv_drv));

    a_r6_bad_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |=> (!bit_tick && frame_clk == frame_inv_drv));

    a_r8_gated_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!bit_tick && frame_clk == frame_inv_drv));

    a_r8_first_half_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(port_en) && drive_clks && !cfg_bad) |=> (frame_clk == frame_inv_drv));

    a_r11_rcv_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rcv_frame_clk == $past(ext_frame_clk ^ frame_inv_rcv)));

    a_r11_rcv_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rcv_bit_clk == $past(ext_bit_clk ^ bit_inv_rcv)));
endmodule

bind audio_clk_ratio_gen aclk_ratio_checker chk_i (.*);

// File: tb/audio_clk_ratio_gen_tb_top.sv
module audio_clk_ratio_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0, drive_clks = 1'b1, wide_codes = 1'b0;
    logic [2:0] mclk_fs_code = 3'd0, bits_frame_code = 3'd0;
    logic       frame_inv_drv = 1'b0, bit_inv_drv = 1'b0;
    logic       frame_inv_rcv = 1'b0, bit_inv_rcv = 1'b0;
    logic       ext_bit_clk = 1'b0, ext_frame_clk = 1'b0;
    logic       bit_tick, frame_clk, rcv_bit_clk, rcv_frame_clk, cfg_bad;

    always #4 clk = ~clk;

    audio_clk_ratio_gen dut_i (.*);

    typedef struct {
        logic  tick;
        logic  fr;
        string req;
    } exp_t;

    exp_t  sb[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    mon_on   = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // bench-side decode from the requirement tables
    function automatic int fs_log(input logic [2:0] c, input logic w);
        case (c)
            3'd0: return 9; 3'd1: return 8; 3'd2: return 7; 3'd3: return 6;
            3'd4: return w ? 5 : 9;
            default: return 9;
        endcase
    endfunction

    function automatic int bf_log(input logic [2:0] c, input logic w);
        case (c)
            3'd0: return 5; 3'd1: return 6; 3'd2: return 7; 3'd3: return 8; 3'd4: return 9;
            3'd7: return w ? 4 : 5;
            default: return 5;
        endcase
    endfunction

    // monitor: compare each master cycle against the scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (mon_on && sb.size() > 0) begin
            e = sb.pop_front();
            check(e.req, "bit_tick", 32'(bit_tick), 32'(e.tick));
            check(e.req, "frame_clk", 32'(frame_clk), 32'(e.fr));
        end
    end

    // driver: program, predict n cycles, enable, wait for the monitor, disable
    task automatic run_case(input logic [2:0] fc, input logic [2:0] bc, input logic w,
                            input logic ib, input logic il, input logic drv,
                            input int n, input string req);
        int m, b, d, dmask, pos_t;
        bit legal;
        exp_t e;
        @(negedge clk);
        port_en = 1'b0;
        mclk_fs_code = fc; bits_frame_code = bc; wide_codes = w;
        bit_inv_drv = ib; frame_inv_drv = il; drive_clks = drv;
        repeat (2) @(negedge clk);
        m = fs_log(fc, w);
        b = bf_log(bc, w);
        legal = (m >= b);
        check({req, " R6"}, "cfg_bad", 32'(cfg_bad), 32'(!legal));
        d = legal ? m - b : 0;
        dmask = (1 << d) - 1;
        pos_t = ib ? (dmask >> 1) : dmask;
        for (int i = 0; i < n; i++) begin
            e.req = req;
            if (legal && drv) begin
                e.tick = ((i & dmask) == pos_t);
                e.fr   = il ^ (((i % (1 << m)) >> (m - 1)) & 1);
            end else begin
                e.tick = 1'b0;
                e.fr   = il;
            end
            sb.push_back(e);
        end
        port_en = 1'b1;
        @(posedge clk);
        #1 mon_on = 1'b1;
        wait (sb.size() == 0);
        mon_on = 1'b0;
        port_en = 1'b0;
        @(negedge clk);
        // R8: one edge after disable the strobes are idle
        check("R8", "bit_tick off", 32'(bit_tick), 32'd0);
        check("R8", "frame_clk idle", 32'(frame_clk), 32'(il));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "bit_tick", 32'(bit_tick), 32'd0);
        check("R1", "frame_clk", 32'(frame_clk), 32'd0);
        check("R1", "rcv_bit_clk", 32'(rcv_bit_clk), 32'd0);
        check("R1", "rcv_frame_clk", 32'(rcv_frame_clk), 32'd0);
        rst_n = 1'b1;

        run_case(3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1100, "R2 R3 512/32");
        run_case(3'd1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 600,  "R2 R3 256/64");
        run_case(3'd3, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 140,  "R2 R3 64/64");
        run_case(3'd2, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 40,   "R3 R6 128/512");
        run_case(3'd2, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 300,  "R9 R10 128/32");
        run_case(3'd3, 3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 70,   "R10 div1");
        run_case(3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 600,  "R4 narrow fs");
        run_case(3'd4, 3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 100,  "R4 wide 32/16");
        run_case(3'd2, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 300,  "R4 narrow bf");
        run_case(3'd6, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 560,  "R5 fallback");
        run_case(3'd4, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 40,   "R6 illegal");
        run_case(3'd2, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 40,   "R7 receive");
        run_case(3'd3, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 200,  "R8 restart");

        // R11: received clocks with polarity controls
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            ext_bit_clk = k[0]; ext_frame_clk = k[1];
            bit_inv_rcv = k[2]; frame_inv_rcv = k[3];
            @(negedge clk);
            check("R11", "rcv_bit_clk", 32'(rcv_bit_clk), 32'(k[0] ^ k[2]));
            check("R11", "rcv_frame_clk", 32'(rcv_frame_clk), 32'(k[1] ^ k[3]));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule